// File: doc/BRIEF.md
# Ready-Flag Serial Reader for a Delta-Sigma Converter

This block is the host-side serial master for a delta-sigma converter running in continuous conversion mode, where the converter's data-out line also acts as its conversion-ready flag. A start pulse makes the block assert chip select and shift out the command that starts continuous conversion. The block then waits for data-out to fall. At each fall it clocks out a flag-clear byte of zeros and then 24 more serial clocks, and it assembles the incoming bits MSB first into a word. It presents that word with a one-cycle valid strobe. The frame carries no explicit read command.

The serial clock comes from the system clock through a parameterised divider. Each bit is a low half of `DIV` system cycles followed by a high half of `DIV` cycles. The host changes its data output at the start of the low half and samples data-out at the rising edge, because the converter changes data-out on the falling edge. A deadline counter limits each frame to `DEADLINE` system cycles, which stands for the conversion period. A frame that overruns is abandoned without a valid strobe and sets a sticky overrun bit. A stop request makes the block answer the next ready fall with an exit command instead of a frame, and then release the port.

Top module: `adc_flag_reader`

## Requirements
- R1: After reset, and whenever the block is idle, `cs_no` is 1, `sclk_o` is 0, `busy_o` is 0, `valid_o` is 0 and `overrun_o` is 0 (the last until an overrun occurs).
- R2: A `start_i` pulse while idle sets `busy_o` and drops `cs_no` in the next cycle. The block then shifts out `CMD_CONT` MSB first on `sdi_o`, one bit per `2*DIV` cycles with `sclk_o` low for the first `DIV` cycles and high for the next `DIV`. The default is 8'hC0: bit 7 is the command-byte marker and bit 6 is the continuous-conversion bit, and every other bit is 0.
- R3: Once the start command is complete, a fall of `sdo_i` (1 in one clock cycle, 0 in the next) starts a frame in the next cycle. A fall that occurs while a command or a frame is being shifted is ignored.
- R4: A frame is 8 serial clocks followed by 24 serial clocks, with `sdi_o` held at 0 for all 32.
- R5: `sdo_i` is sampled at each rising `sclk_o` edge. `word_o` receives the last 24 samples of the frame, with the first of them in bit 23.
- R6: `valid_o` is high for exactly one cycle, the cycle after the frame's last serial clock falls, and `word_o` changes only in that cycle.
- R7: A frame still running `DEADLINE` cycles after it started is abandoned. Then `valid_o` stays low, `overrun_o` goes to 1 and stays at 1 until the next accepted start, and the block waits for the next fall.
- R8: When `stop_i` has been seen while busy, the next fall sends `CMD_EXIT` (default 8'h80) instead of a frame, after which `busy_o` drops and `cs_no` rises.
- R9: After each frame the block waits again. A fall that follows a single high cycle on `sdo_i` starts a new frame, so each fall yields a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: enter continuous conversion |
| stop_i | input | 1 | Pulse: leave continuous mode at next ready fall |
| sdo_i | input | 1 | Converter data-out / ready flag |
| sclk_o | output | 1 | Serial clock |
| sdi_o | output | 1 | Serial data to converter |
| cs_no | output | 1 | Chip select, active low |
| busy_o | output | 1 | Block is out of idle |
| word_o | output | 24 | Last conversion word |
| valid_o | output | 1 | One-cycle strobe for word_o |
| overrun_o | output | 1 | Sticky: a frame missed its deadline |

## Verification
The assertions check the following on every cycle:
- the serial clock stays low while idle;
- `sdi_o` stays zero throughout a frame;
- the valid strobe lasts a single cycle, comes straight out of a frame and never coincides with an overrun;
- the overrun bit holds while busy.

Only the bench scenarios can show the rest:
- the command bit order and serial clock phases;
- a ready fall ignored during the start command;
- MSB-first assembly of several words, including back-to-back words separated by a single high cycle;
- the exit command on stop;
- the overrun path, using a second instance with a deadline shorter than a frame.

// File: rtl/adc_flag_reader_pkg.sv
package adc_flag_reader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_FRAME,
    ST_EXIT
  } rd_state_e;
endpackage

// File: rtl/afr_sclk_gen.sv
module afr_sclk_gen #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic rise_o,
  output logic fall_o,
  output logic sclk_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == CNT_MAX);
  assign rise_o = wrap && !ph_q;
  assign fall_o = wrap && ph_q;
  assign sclk_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        cnt_q <= '0;
        ph_q  <= ~ph_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/afr_shifter.sv
module afr_shifter #(
  parameter int CMD_W  = 8,
  parameter int CLR_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              abort_i,
  input  logic              is_frame_i,
  input  logic [CMD_W-1:0]  tx_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdo_i,
  output logic              active_o,
  output logic              done_o,
  output logic              sdi_o,
  output logic [WORD_W-1:0] rx_o
);
  localparam int FRAME_BITS = CLR_W + WORD_W;
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [BIT_W-1:0] LAST_FRAME = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] LAST_CMD   = BIT_W'(CMD_W - 1);

  logic [BIT_W-1:0]  bitn_q;
  logic [CMD_W-1:0]  tx_q;
  logic              frame_q;
  logic              last;

  assign last     = bitn_q == (frame_q ? LAST_FRAME : LAST_CMD);
  assign done_o   = active_o && fall_i && last;
  assign sdi_o    = tx_q[CMD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      bitn_q   <= '0;
      tx_q     <= '0;
      frame_q  <= 1'b0;
      rx_o     <= '0;
    end else begin
      if (go_i) begin
        active_o <= 1'b1;
        bitn_q   <= '0;
        tx_q     <= tx_i;
        frame_q  <= is_frame_i;
      end else if (abort_i) begin
        active_o <= 1'b0;
        tx_q     <= '0;
      end else if (active_o && fall_i) begin
        tx_q   <= {tx_q[CMD_W-2:0], 1'b0};
        bitn_q <= bitn_q + 1'b1;
        if (last) active_o <= 1'b0;
      end
      if (active_o && rise_i) rx_o <= {rx_o[WORD_W-2:0], sdo_i};
    end
  end
endmodule

// File: rtl/afr_deadline.sv
module afr_deadline #(
  parameter int DEADLINE = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int DL_W = $clog2(DEADLINE + 1);
  localparam logic [DL_W-1:0] DL_LAST = DL_W'(DEADLINE - 1);

  logic [DL_W-1:0] cnt_q;

  assign expired_o = en_i && (cnt_q == DL_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import adc_flag_reader_pkg::*;
#(
  parameter int          CMD_W    = 8,
  parameter int          WORD_W   = 24,
  parameter logic [7:0]  CMD_CONT = 8'hC0,
  parameter logic [7:0]  CMD_EXIT = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sdo_i,
  input  logic              done_i,
  input  logic              expired_i,
  input  logic [WORD_W-1:0] rx_i,
  output logic              go_o,
  output logic              abort_o,
  output logic              is_frame_o,
  output logic [CMD_W-1:0]  tx_o,
  output logic              frame_o,
  output logic              busy_o,
  output logic              cs_no,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              overrun_o
);
  rd_state_e state_q, state_d;
  logic      sdo_q, stop_pend_q, fall_det, stop_any;

  assign fall_det = sdo_q && !sdo_i;
  assign stop_any = stop_pend_q || stop_i;
  assign frame_o  = state_q == ST_FRAME;
  assign busy_o   = state_q != ST_IDLE;
  assign cs_no    = state_q == ST_IDLE;
  assign abort_o  = frame_o && expired_i && !done_i;

  always_comb begin
    state_d    = state_q;
    go_o       = 1'b0;
    is_frame_o = 1'b0;
    tx_o       = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CMD;
        go_o    = 1'b1;
        tx_o    = CMD_W'(CMD_CONT);
      end
      ST_CMD:  if (done_i) state_d = ST_WAIT;
      ST_WAIT: if (fall_det) begin
        go_o = 1'b1;
        if (stop_any) begin
          state_d = ST_EXIT;
          tx_o    = CMD_W'(CMD_EXIT);
        end else begin
          state_d    = ST_FRAME;
          is_frame_o = 1'b1;
        end
      end
      ST_FRAME: if (done_i || expired_i) state_d = ST_WAIT;
      ST_EXIT:  if (done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sdo_q       <= 1'b1;
      stop_pend_q <= 1'b0;
      valid_o     <= 1'b0;
      word_o      <= '0;
      overrun_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      sdo_q   <= sdo_i;
      valid_o <= 1'b0;
      if (state_d == ST_IDLE)                 stop_pend_q <= 1'b0;
      else if (stop_i && state_q != ST_IDLE)  stop_pend_q <= 1'b1;
      if (state_q == ST_IDLE && start_i) overrun_o <= 1'b0;
      if (frame_o && done_i) begin
        valid_o <= 1'b1;
        word_o  <= rx_i;
      end else if (abort_o) begin
        overrun_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_flag_reader.sv
module adc_flag_reader #(
  parameter int          DIV      = 2,
  parameter int          CMD_W    = 8,
  parameter int          CLR_W    = 8,
  parameter int          WORD_W   = 24,
  parameter int          DEADLINE = 160,
  parameter logic [7:0]  CMD_CONT = 8'hC0,
  parameter logic [7:0]  CMD_EXIT = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sdo_i,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              cs_no,
  output logic              busy_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              overrun_o
);
  logic go, abort, is_frame, active, done, rise, fall, expired, in_frame;
  logic [CMD_W-1:0]  tx;
  logic [WORD_W-1:0] rx;

  afr_sclk_gen #(.DIV(DIV)) u_sclk (
    .clk_i, .rst_ni,
    .run_i (active),
    .clr_i (go || abort),
    .rise_o(rise),
    .fall_o(fall),
    .sclk_o(sclk_o)
  );

  afr_shifter #(.CMD_W(CMD_W), .CLR_W(CLR_W), .WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni,
    .go_i      (go),
    .abort_i   (abort),
    .is_frame_i(is_frame),
    .tx_i      (tx),
    .rise_i    (rise),
    .fall_i    (fall),
    .sdo_i     (sdo_i),
    .active_o  (active),
    .done_o    (done),
    .sdi_o     (sdi_o),
    .rx_o      (rx)
  );

  afr_deadline #(.DEADLINE(DEADLINE)) u_dl (
    .clk_i, .rst_ni,
    .clr_i    (go),
    .en_i     (in_frame),
    .expired_o(expired)
  );

  afr_ctrl #(
    .CMD_W(CMD_W), .WORD_W(WORD_W), .CMD_CONT(CMD_CONT), .CMD_EXIT(CMD_EXIT)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .start_i, .stop_i, .sdo_i,
    .done_i    (done),
    .expired_i (expired),
    .rx_i      (rx),
    .go_o      (go),
    .abort_o   (abort),
    .is_frame_o(is_frame),
    .tx_o      (tx),
    .frame_o   (in_frame),
    .busy_o    (busy_o),
    .cs_no     (cs_no),
    .valid_o   (valid_o),
    .word_o    (word_o),
    .overrun_o (overrun_o)
  );
endmodule

// File: rtl/adc_flag_reader_chk.sv
module adc_flag_reader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic sdi_o,
  input logic busy_o,
  input logic valid_o,
  input logic overrun_o,
  input logic frame_i
);
  assert_idle_sclk_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  assert_frame_zero_sdi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |-> !sdi_o);
  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_valid_after_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> busy_o && $past(frame_i));
  assert_overrun_no_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> !valid_o);
  assert_overrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && busy_o |=> overrun_o);
endmodule

bind adc_flag_reader adc_flag_reader_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_o   (sclk_o),
  .sdi_o    (sdi_o),
  .busy_o   (busy_o),
  .valid_o  (valid_o),
  .overrun_o(overrun_o),
  .frame_i  (in_frame)
);

// File: tb/adc_flag_reader_bench.sv
`timescale 1ns/1ps
module adc_flag_reader_bench;
  localparam int DIV = 2;
  localparam int DEADLINE = 160;
  localparam int TIGHT_DL = 40;
  localparam logic [7:0] CMD_CONT = 8'hC0;
  localparam logic [7:0] CMD_EXIT = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0, sdo = 1'b1;
  logic sclk, sdi, cs_n, busy, valid, ovr;
  logic [23:0] word;
  logic t_sclk, t_sdi, t_cs_n, t_busy, t_valid, t_ovr;
  logic [23:0] t_word;

  int checks = 0, fails = 0;
  logic [23:0] got_q[$];
  logic [23:0] exp_q[$];
  int t_valid_cnt = 0;
  logic [23:0] cur_word = '0;

  always #5 clk = ~clk;

  adc_flag_reader #(.DIV(DIV), .DEADLINE(DEADLINE), .CMD_CONT(CMD_CONT), .CMD_EXIT(CMD_EXIT))
  u_adc_flag_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .sdo_i(sdo),
    .sclk_o(sclk), .sdi_o(sdi), .cs_no(cs_n), .busy_o(busy),
    .word_o(word), .valid_o(valid), .overrun_o(ovr)
  );

  adc_flag_reader #(.DIV(DIV), .DEADLINE(TIGHT_DL)) u_tight (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .sdo_i(sdo),
    .sclk_o(t_sclk), .sdi_o(t_sdi), .cs_no(t_cs_n), .busy_o(t_busy),
    .word_o(t_word), .valid_o(t_valid), .overrun_o(t_ovr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: 0 idle, 1 start cmd, 2 waiting, 3 frame, 4 exit cmd
  int m_mode = 0, m_t = 0;
  bit m_sp = 0, m_prev = 1, e_valid = 0, e_ovr = 0;
  logic [23:0] e_word = '0;

  always @(posedge clk) begin
    int old;
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_sp = 0; m_prev = 1; e_valid = 0; e_ovr = 0;
    end else begin
      old = m_mode;
      e_valid = 0;
      case (m_mode)
        0: if (start) begin m_mode = 1; m_t = 0; e_ovr = 0; end
        1, 4: begin
          m_t++;
          if (m_t == 16*DIV) m_mode = (m_mode == 1) ? 2 : 0;
        end
        2: if (m_prev && !sdo) begin m_mode = (m_sp || stop) ? 4 : 3; m_t = 0; end
        3: begin
          m_t++;
          if (m_t == 64*DIV) begin m_mode = 2; e_valid = 1; e_word = cur_word; end
          else if (m_t == DEADLINE) begin m_mode = 2; e_ovr = 1; end
        end
        default: m_mode = 0;
      endcase
      if (m_mode == 0) m_sp = 0;
      else if (stop && old != 0) m_sp = 1;
      m_prev = sdo;
    end
  end

  always @(negedge clk) begin
    bit e_sclk, e_sdi;
    if (rst_n) begin
      e_sclk = 0; e_sdi = 0;
      if (m_mode == 1 || m_mode == 3 || m_mode == 4) e_sclk = (m_t % (2*DIV)) >= DIV;
      if (m_mode == 1) e_sdi = CMD_CONT[7 - m_t/(2*DIV)];
      if (m_mode == 4) e_sdi = CMD_EXIT[7 - m_t/(2*DIV)];
      chk(cs_n == (m_mode == 0), "R1 cs_no", cs_n, m_mode == 0);
      chk(busy == (m_mode != 0), "R1 busy", busy, m_mode != 0);
      chk(sclk == e_sclk, "R2 sclk", sclk, e_sclk);
      chk(sdi == e_sdi, (m_mode == 3) ? "R4 sdi" : (m_mode == 4) ? "R8 sdi" : "R2 sdi", sdi, e_sdi);
      chk(valid == e_valid, "R6 valid", valid, e_valid);
      if (e_valid) chk(word == e_word, "R5 word", word, e_word);
      chk(ovr == e_ovr, "R7 overrun", ovr, e_ovr);
      if (valid) got_q.push_back(word);
      if (t_valid) t_valid_cnt++;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // converter: flag fall, hold low through flag-clear, bits change after falling sclk
  task automatic serve(input logic [23:0] w);
    cur_word = w;
    exp_q.push_back(w);
    @(negedge clk) sdo = 1'b0;
    repeat (16*DIV + 1) @(negedge clk);
    for (int j = 23; j >= 0; j--) begin
      sdo = w[j];
      repeat (2*DIV) @(negedge clk);
    end
    sdo = 1'b1;
  endtask

  initial begin
    cycles(100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cycles(3);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 reset cs_no", cs_n, 1);
    chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(valid == 1'b0, "R1 reset valid", valid, 0);
    chk(ovr == 1'b0, "R1 reset overrun", ovr, 0);
    rst_n = 1'b1;
    cycles(3);
    // R2 start command
    start = 1'b1; cycles(1); start = 1'b0;
    // R3 fall during the start command is ignored
    cycles(4); sdo = 1'b0; cycles(3); sdo = 1'b1;
    cycles(16*DIV);
    chk(got_q.size() == 0, "R3 ignored fall count", got_q.size(), 0);
    // R5/R9 words, back to back with one high cycle between
    serve(24'hA5C31E);
    cycles(7);
    serve(24'h000001);
    serve(24'hFFFFFE);
    serve(24'h800000);
    cycles(4);
    chk(got_q.size() == exp_q.size(), "R9 word count", got_q.size(), exp_q.size());
    foreach (exp_q[i]) begin
      if (i < got_q.size()) chk(got_q[i] == exp_q[i], "R5 word value", got_q[i], exp_q[i]);
    end
    // R7 on the tight instance: abandoned frames, sticky overrun
    chk(t_valid_cnt == 0, "R7 tight valid count", t_valid_cnt, 0);
    chk(t_ovr == 1'b1, "R7 tight overrun", t_ovr, 1);
    chk(ovr == 1'b0, "R7 main overrun", ovr, 0);
    // R8 stop then next fall sends exit command
    stop = 1'b1; cycles(1); stop = 1'b0;
    cycles(5);
    sdo = 1'b0;
    cycles(16*DIV + 4);
    sdo = 1'b1;
    cycles(2);
    chk(busy == 1'b0, "R8 busy after exit", busy, 0);
    chk(cs_n == 1'b1, "R8 cs_no after exit", cs_n, 1);
    chk(got_q.size() == exp_q.size(), "R8 no extra word", got_q.size(), exp_q.size());
    chk(t_ovr == 1'b1, "R7 tight overrun held", t_ovr, 1);
    // R2 restart
    start = 1'b1; cycles(1); start = 1'b0;
    cycles(16*DIV + 6);
    chk(busy == 1'b1, "R2 busy after restart", busy, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule